// File: doc/BRIEF.md
# Polled Protection-Status I2C Target

This block is an I2C target that a polling host reads to learn the protection status of up to eight supply lines. SCL and SDA are oversampled with the system clock through a synchronizer. START and STOP are detected on the synchronized copies. The target answers a read to its own 7-bit address and ignores all other traffic. Its address is a fixed base plus a small offset taken from strap pins, so several identical targets can share one bus.

Each read returns a frame built from two masks: the occupancy mask of the lines, then the short-circuit mask. Both masks are captured together at the moment the address byte matches. The bytes of one frame therefore always describe the same instant, even if the inputs change while the frame is being clocked out. The target drives SDA open-drain through an output enable: a high enable pulls the line low. It answers consecutive read transactions with no idle gap required between them.

Top module: `stat_i2c_tgt`

## Requirements
- R1: The target address is ADDR_BASE (default 0x58) plus the 3-bit strap offset. The target pulls SDA low in the acknowledge slot only for that address with the R/W bit (bit 0 of the address byte) at 1.
- R2: Any other address is not acknowledged, and SDA stays released for the rest of that transaction.
- R3: A matching address with the R/W bit at 0 (a write) is not acknowledged.
- R4: The first data byte of a read is the occupancy mask and the second is the short mask. Bit n of each byte stands for line n. Each byte is sent MSB first.
- R5: Both masks are sampled together on the eighth SCL rising edge of a matching address byte. Changes to the mask inputs after that edge do not alter the frame being read.
- R6: Data bytes requested after the second return 0xFF.
- R7: A NACK from the host after a data byte ends the transfer. SDA stays released until the next START, even if SCL keeps clocking.
- R8: A STOP releases SDA and returns the target to idle. A START, including a repeated START, begins a new address phase, so back-to-back reads each return a complete frame.
- R9: The SDA output enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_ofs | input | 3 | Address offset added to the base address |
| occ_mask | input | 8 | Occupancy flag per line, bit n = line n |
| short_mask | input | 8 | Short-circuit flag per line, bit n = line n |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
A wrong state register here shows up at the bus within a single bit slot. A lost or extra shift moves every later data bit, so the byte read back is a rotated or misaligned copy of the expected mask. A stuck transmit or acknowledge state holds SDA low and blocks the STOP or the next START. A snapshot taken at the wrong time appears only when the mask inputs change in the middle of a frame, so the bench changes them right after the address acknowledge. Wrong address decoding shows up as an acknowledge bit of the wrong polarity in the ninth slot of the address byte.

// File: rtl/stat_i2c_pkg.sv
package stat_i2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_PEND,
      ST_ACK,
      ST_TX,
      ST_HACK,
      ST_HACK_GO,
      ST_IGNORE
   } tgt_state_t;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/stat_bus_sync.sv
module stat_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic start_o,
   output logic stop_o,
   output logic scl_rise_o,
   output logic scl_fall_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("stat_bus_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_o      = scl_ff[STAGES-1];
   assign sda_o      = sda_ff[STAGES-1];
   assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
   assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
   assign scl_rise_o = scl_o & ~scl_q;
   assign scl_fall_o = ~scl_o & scl_q;

endmodule

// File: rtl/stat_frame_sel.sv
module stat_frame_sel #(
   parameter int         LINES = 8,
   parameter logic [7:0] FILL  = 8'hFF,
   localparam int NB    = LINES / 8,
   localparam int FB    = 2 * NB,
   localparam int IDX_W = $clog2(FB + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [LINES-1:0] occ_i,
   input  logic [LINES-1:0] sht_i,
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       byte_o
);

   generate
      if ((LINES % 8) != 0 || LINES < 8) begin : g_bad_lines
         $error("stat_frame_sel: LINES must be a positive multiple of 8");
      end
   endgenerate

   logic [LINES-1:0]   occ_snap;
   logic [LINES-1:0]   sht_snap;
   logic [2*LINES-1:0] frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_snap <= '0;
         sht_snap <= '0;
      end else if (capture) begin
         occ_snap <= occ_i;
         sht_snap <= sht_i;
      end
   end

   assign frame = {sht_snap, occ_snap};

   generate
      if (FB == 2) begin : g_two_byte
         always_comb begin
            case (idx)
               IDX_W'(0): byte_o = frame[7:0];
               IDX_W'(1): byte_o = frame[15:8];
               default:   byte_o = FILL;
            endcase
         end
      end else begin : g_multi_byte
         always_comb begin
            byte_o = FILL;
            for (int k = 0; k < FB; k++) begin
               if (idx == IDX_W'(k)) byte_o = frame[k*8 +: 8];
            end
         end
      end
   endgenerate

   // R5
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> ($stable(occ_snap) && $stable(sht_snap)));

endmodule

// File: rtl/stat_i2c_tgt.sv
module stat_i2c_tgt
   import stat_i2c_pkg::*;
#(
   parameter logic [6:0] ADDR_BASE   = 7'h58,
   parameter int         OFS_W       = 3,
   parameter int         LINES       = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] FILL_BYTE   = 8'hFF,
   localparam int NB    = LINES / 8,
   localparam int FB    = 2 * NB,
   localparam int IDX_W = $clog2(FB + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OFS_W-1:0] strap_ofs,
   input  logic [LINES-1:0] occ_mask,
   input  logic [LINES-1:0] short_mask,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe
);

   generate
      if (OFS_W < 1 || OFS_W > 6) begin : g_bad_ofs
         $error("stat_i2c_tgt: OFS_W out of range");
      end
      if ((int'(ADDR_BASE) + (1 << OFS_W) - 1) > 127) begin : g_bad_base
         $error("stat_i2c_tgt: ADDR_BASE plus offset overflows 7 bits");
      end
   endgenerate

   logic scl_s, sda_s, bus_start, bus_stop, scl_rise, scl_fall;

   stat_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_s),
      .sda_o      (sda_s),
      .start_o    (bus_start),
      .stop_o     (bus_stop),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall)
   );

   tgt_state_t       state;
   logic [7:0]       sreg;
   logic [2:0]       bitcnt;
   logic [7:0]       tx_sh;
   logic [IDX_W-1:0] idx;
   logic [6:0]       tgt_addr;
   logic             addr_hit;
   logic             capture;
   logic [7:0]       cur_byte;
   logic [IDX_W-1:0] idx_next;

   assign tgt_addr = ADDR_BASE + 7'(strap_ofs);
   assign addr_hit = ({sreg[6:0], sda_s} == {tgt_addr, 1'b1});
   assign capture  = (state == ST_ADDR) && scl_rise && (bitcnt == 3'd7)
                     && addr_hit && !bus_start && !bus_stop;
   assign idx_next = (idx == IDX_W'(FB)) ? idx : idx + 1'b1;

   stat_frame_sel #(.LINES(LINES), .FILL(FILL_BYTE)) i_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .occ_i   (occ_mask),
      .sht_i   (short_mask),
      .idx     (idx),
      .byte_o  (cur_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         sreg   <= '0;
         bitcnt <= '0;
         tx_sh  <= '0;
         idx    <= '0;
      end else if (bus_stop) begin
         state <= ST_IDLE;
      end else if (bus_start) begin
         state  <= ST_ADDR;
         bitcnt <= '0;
      end else begin
         case (state)
            ST_ADDR: begin
               if (scl_rise) begin
                  sreg   <= {sreg[6:0], sda_s};
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) state <= addr_hit ? ST_ACK_PEND : ST_IGNORE;
               end
            end
            ST_ACK_PEND: begin
               if (scl_fall) begin
                  state <= ST_ACK;
                  idx   <= '0;
               end
            end
            ST_ACK, ST_HACK_GO: begin
               if (scl_fall) begin
                  tx_sh  <= cur_byte;
                  idx    <= idx_next;
                  bitcnt <= '0;
                  state  <= ST_TX;
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bitcnt == 3'd7) begin
                     state <= ST_HACK;
                  end else begin
                     tx_sh  <= {tx_sh[6:0], 1'b1};
                     bitcnt <= bitcnt + 3'd1;
                  end
               end
            end
            ST_HACK: begin
               if (scl_rise) state <= sda_s ? ST_IGNORE : ST_HACK_GO;
            end
            default: state <= state;
         endcase
      end
   end

   always_comb begin
      case (state)
         ST_ACK:  sda_oe = 1'b1;
         ST_TX:   sda_oe = ~tx_sh[7];
         default: sda_oe = 1'b0;
      endcase
   end

   // R9
   oe_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_oe));

   // R8
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> !sda_oe);

   // R1
   ack_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACK) |-> (sreg[7:1] == tgt_addr && sreg[0]));

   // R7
   nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HACK && scl_rise && sda_s && !bus_start && !bus_stop)
         |=> (state == ST_IGNORE && !sda_oe));

   // R2
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR && scl_rise && bitcnt == 3'd7 && !addr_hit
       && !bus_start && !bus_stop) |=> !sda_oe);

endmodule

// File: tb/test_stat_i2c_tgt.sv
module test_stat_i2c_tgt;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] strap_ofs = 3'd0;
   logic [7:0] occ_mask = 8'h00;
   logic [7:0] short_mask = 8'h00;
   logic       scl = 1'b1;
   logic       m_low = 1'b0;
   logic       sda_oe;
   logic       sda_line;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   assign sda_line = ~(sda_oe | m_low);

   stat_i2c_tgt i_stat_i2c_tgt (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_ofs  (strap_ofs),
      .occ_mask   (occ_mask),
      .short_mask (short_mask),
      .scl_i      (scl),
      .sda_i      (sda_line),
      .sda_oe     (sda_oe)
   );

   function automatic bit exp_ack(input logic [6:0] a, input bit rd, input logic [2:0] ofs);
      return rd && (a == 7'h58 + 7'(ofs));
   endfunction

   function automatic logic [7:0] exp_byte(input int k, input logic [7:0] o, input logic [7:0] s);
      if (k == 0) return o;
      if (k == 1) return s;
      return 8'hFF;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      m_low = 1'b0; tick(Q);
      scl = 1'b1;   tick(Q);
      m_low = 1'b1; tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      m_low = 1'b0; tick(2*Q);
   endtask

   task automatic put_bit(input bit b);
      m_low = ~b;   tick(Q);
      scl = 1'b1;   tick(2*Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic get_bit(output bit b);
      m_low = 1'b0; tick(Q);
      scl = 1'b1;   tick(Q);
      b = sda_line; tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   // sends address byte, returns 1 when the target acknowledged
   task automatic send_addr(input logic [6:0] a, input bit rd, output bit ack);
      bit b;
      for (int i = 6; i >= 0; i--) put_bit(a[i]);
      put_bit(rd);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic get_byte(input bit host_ack, output logic [7:0] v);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(~host_ack);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      bit         ack;
      logic [7:0] v;
      logic [7:0] eo, es;
      process::self().srandom(32'h5EED_0042);
      tick(4);
      chk(sda_oe == 1'b0, "R8 reset release", sda_oe, 0);
      rst_n = 1'b1;
      tick(4);

      // directed: matching read, snapshot, fill byte
      strap_ofs = 3'd5; occ_mask = 8'hA5; short_mask = 8'h3C;
      bus_start();
      send_addr(7'h5D, 1'b1, ack);
      chk(ack, "R1 ack offset 5", ack, 1);
      occ_mask = 8'h00; short_mask = 8'hFF; // R5: change after capture
      get_byte(1'b1, v); chk(v == 8'hA5, "R4 R5 occupancy byte", v, 8'hA5);
      get_byte(1'b1, v); chk(v == 8'h3C, "R4 R5 short byte", v, 8'h3C);
      get_byte(1'b0, v); chk(v == 8'hFF, "R6 third byte fill", v, 8'hFF);
      bus_stop();
      chk(sda_oe == 1'b0, "R8 stop release", sda_oe, 0);

      // R2: wrong offset
      bus_start();
      send_addr(7'h5C, 1'b1, ack);
      chk(!ack, "R2 wrong address nack", ack, 0);
      get_byte(1'b0, v); chk(v == 8'hFF, "R2 bus released", v, 8'hFF);
      bus_stop();

      // R3: write to own address
      bus_start();
      send_addr(7'h5D, 1'b0, ack);
      chk(!ack, "R3 write nack", ack, 0);
      bus_stop();

      // R7: host nack, then keep clocking; short mask 0x00 would show if still driven
      occ_mask = 8'h81; short_mask = 8'h00;
      bus_start();
      send_addr(7'h5D, 1'b1, ack);
      chk(ack, "R1 ack before nack test", ack, 1);
      get_byte(1'b0, v); chk(v == 8'h81, "R4 first byte", v, 8'h81);
      get_byte(1'b0, v); chk(v == 8'hFF, "R7 released after nack", v, 8'hFF);
      // R8: repeated start after nack gives a new full frame
      occ_mask = 8'h12; short_mask = 8'h34;
      bus_start();
      send_addr(7'h5D, 1'b1, ack);
      chk(ack, "R8 repeated start ack", ack, 1);
      get_byte(1'b1, v); chk(v == 8'h12, "R8 repeated start byte0", v, 8'h12);
      get_byte(1'b0, v); chk(v == 8'h34, "R8 repeated start byte1", v, 8'h34);
      bus_stop();

      // random back-to-back traffic
      for (int it = 0; it < 24; it++) begin
         logic [6:0] a;
         bit rd;
         int nb;
         strap_ofs  = 3'($urandom_range(0, 7));
         occ_mask   = 8'($urandom);
         short_mask = 8'($urandom);
         eo = occ_mask; es = short_mask;
         a  = ($urandom_range(0, 9) < 7) ? 7'h58 + 7'(strap_ofs) : 7'($urandom);
         rd = ($urandom_range(0, 3) != 0);
         nb = $urandom_range(1, 4);
         bus_start();
         send_addr(a, rd, ack);
         chk(ack == exp_ack(a, rd, strap_ofs), "R1 R2 R3 random address", ack, exp_ack(a, rd, strap_ofs));
         if (ack) begin
            occ_mask = ~eo; short_mask = ~es;
            for (int k = 0; k < nb; k++) begin
               get_byte(k != nb - 1, v);
               chk(v == exp_byte(k, eo, es), "R4 R5 R6 random byte", v, exp_byte(k, eo, es));
            end
         end
         bus_stop();
         chk(sda_oe == 1'b0, "R8 random stop release", sda_oe, 0);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // R9 observed at the pins: SDA enable must hold while SCL is high past the synchronizer
   logic scl_d1, scl_d2, scl_d3, oe_d;
   always @(posedge clk) begin
      scl_d1 <= scl; scl_d2 <= scl_d1; scl_d3 <= scl_d2; oe_d <= sda_oe;
      if (rst_n && scl && scl_d1 && scl_d2 && scl_d3 && (oe_d !== sda_oe)) begin
         checks++;
         errors++;
         $display("FAIL R9: actual 0x%0h expected 0x%0h", sda_oe, oe_d);
      end
   end

endmodule